// File: doc/BRIEF.md
# Four-Pair Synchronized Scrambler Generator

This block produces the scrambling masks for a transceiver that drives four wire-pairs in parallel. A single 33-bit linear feedback shift register advances one step per enabled symbol (one symbol every 40 ns at the 25 MHz symbol rate). A strap input chooses between two feedback polynomials:
- 1 + x^13 + x^33 on the master side.
- 1 + x^20 + x^33 on the slave side.

The two ends of a link therefore run different sequences.

On each step, every pair takes a 10-bit mask and one sign bit from the register's bit history. The 10-bit mask is XORed into that pair's data word, and the sign bit randomizes the polarity of the pair's lower-band symbol. Each pair reads a different window of the same history. The four pair streams are therefore shifted copies of one base stream, spaced by a constant number of symbols. This keeps them uncorrelated from symbol to symbol, yet lets a receiver align them from their fixed offsets.

Bit history beyond the 33 stored bits is rebuilt from the active polynomial's recurrence. A synchronous seed load sets the register. An all-zero seed would lock the register, so it is replaced by a fixed nonzero default.

Top module: `scr4_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the register takes the default state 33'h1_2345_6789, and `scr_o` and `sign_o` become all zero.
- R2: A step is an edge with `step_en`=1, `seed_load`=0 and `rst`=0. On a step with `master_sel`=1, the state s becomes {s[31:0], s[32]^s[12]}.
- R3: On a step with `master_sel`=0, the state s becomes {s[31:0], s[32]^s[19]}.
- R4: At an edge with neither `step_en` nor `seed_load` high, the state, `scr_o` and `sign_o` all keep their values.
- R5: At an edge with `seed_load`=1 and a nonzero `seed_val`, the state becomes `seed_val`. This holds even when `step_en` is also high, and `scr_o` and `sign_o` keep their values at that edge.
- R6: A `seed_load` with `seed_val`=0 loads the default 33'h1_2345_6789 instead, so the state is never zero.
- R7: History bit h[i] equals s[i] for i<33. For i>=33, h[i] = h[i-33] ^ h[i-33+k], where k is 13 when `master_sel`=1 and 20 when `master_sel`=0. After a step, `scr_o` bit 10p+j (pair p in 0..3, bit j in 0..9) equals `data_i` bit 10p+j XOR h[11p+j], taken from the state before the step.
- R8: After a step, `sign_o[p]` equals h[11p+10] of the state before the step.
- R9: When no load or polynomial change occurs in between, the 11-bit mask of pair p (data bits, then sign at bit 10) at step n equals pair 0's mask at step n-11p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load `seed_val` into the register (priority over stepping) |
| seed_val | input | 33 | Seed state; zero selects the default |
| step_en | input | 1 | Advance one symbol and register new outputs |
| master_sel | input | 1 | 1 selects the master polynomial, 0 the slave polynomial |
| data_i | input | 40 | Four 10-bit data words, pair p in bits 10p+9..10p |
| scr_o | output | 40 | Four scrambled 10-bit words, same layout as `data_i` |
| sign_o | output | 4 | Lower-band sign-randomizing bit for each pair |

## Verification
On every cycle, the assertions check the following:
- The shift and feedback for both polynomials.
- Holding when idle.
- The seed load, including the zero-seed substitution and that the state never becomes zero.
- The reset values.
- That pair 0's sign bit follows the history bit it is taken from.

The bench compares the output words and sign bits against a bit-serial reference register for both polynomials under several data patterns. It also checks that XORing the recovered mask back restores the data. Only a long run of uninterrupted steps can show the fixed delay between pair streams, so the bench checks it separately by comparing each pair's recovered masks with pair 0's masks from 11, 22 and 33 symbols earlier.

// File: rtl/scr4_pkg.sv
package scr4_pkg;

    localparam int STATE_BITS   = 33;
    localparam int TAP_M_DEF    = 13;
    localparam int TAP_S_DEF    = 20;
    localparam int LANES_DEF    = 4;
    localparam int WORD_BITS    = 10;
    localparam logic [STATE_BITS-1:0] SEED_DEF = 33'h1_2345_6789;

    typedef enum logic {
        POLY_SLAVE  = 1'b0,
        POLY_MASTER = 1'b1
    } poly_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } lfsr_op_e;

    function automatic lfsr_op_e decode_op(input logic load, input logic step);
        if (load)
            return OP_LOAD;
        else if (step)
            return OP_STEP;
        else
            return OP_HOLD;
    endfunction

    function automatic logic [STATE_BITS-1:0] fix_seed(
        input logic [STATE_BITS-1:0] seed,
        input logic [STATE_BITS-1:0] dflt
    );
        return (seed == '0) ? dflt : seed;
    endfunction

endpackage

// File: rtl/scr4_lfsr.sv
module scr4_lfsr
    import scr4_pkg::*;
#(
    parameter int                  W      = STATE_BITS,
    parameter int                  TAP_M  = TAP_M_DEF,
    parameter int                  TAP_S  = TAP_S_DEF,
    parameter logic [W-1:0]        DEFV   = SEED_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    input  poly_e        poly,
    output logic [W-1:0] state
);

    logic     fb;
    lfsr_op_e op;

    always_comb begin
        op = decode_op(load, step);
        if (poly == POLY_MASTER)
            fb = state[W-1] ^ state[TAP_M-1];
        else
            fb = state[W-1] ^ state[TAP_S-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DEFV;
        end else begin
            case (op)
                OP_LOAD: state <= fix_seed(seed, DEFV);
                OP_STEP: state <= {state[W-2:0], fb};
                default: state <= state;
            endcase
        end
    end

endmodule

// File: rtl/scr4_hist_ext.sv
module scr4_hist_ext
    import scr4_pkg::*;
#(
    parameter int W      = STATE_BITS,
    parameter int TAP_M  = TAP_M_DEF,
    parameter int TAP_S  = TAP_S_DEF,
    parameter int HIST_W = 44
) (
    input  logic [W-1:0]      state,
    input  poly_e             poly,
    output logic [HIST_W-1:0] hist
);

    // Bit i is the sequence value i symbols back. Beyond the stored window
    // the recurrence x(m-33) = x(m) ^ x(m-k) rebuilds older bits.
    for (genvar i = 0; i < HIST_W; i++) begin : g_bit
        if (i < W) begin : g_direct
            assign hist[i] = state[i];
        end else begin : g_rebuilt
            localparam int M = i - W;
            logic bit_m;
            logic bit_s;
            assign bit_m = state[M] ^ state[M + TAP_M];
            assign bit_s = state[M] ^ state[M + TAP_S];
            assign hist[i] = (poly == POLY_MASTER) ? bit_m : bit_s;
        end
    end

endmodule

// File: rtl/scr4_lane.sv
module scr4_lane
    import scr4_pkg::*;
#(
    parameter int WB = WORD_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [WB-1:0] data,
    input  logic [WB:0]   mask,
    output logic [WB-1:0] word,
    output logic          sign
);

    lfsr_op_e op;
    assign op = decode_op(load, step);

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            sign <= 1'b0;
        end else if (op == OP_STEP) begin
            word <= data ^ mask[WB-1:0];
            sign <= mask[WB];
        end
    end

endmodule

// File: rtl/scr4_gen.sv
module scr4_gen
    import scr4_pkg::*;
#(
    parameter int                     W      = STATE_BITS,
    parameter int                     LANES  = LANES_DEF,
    parameter int                     WB     = WORD_BITS,
    parameter int                     TAP_M  = TAP_M_DEF,
    parameter int                     TAP_S  = TAP_S_DEF,
    parameter logic [STATE_BITS-1:0]  DEFV   = SEED_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                seed_load,
    input  logic [W-1:0]        seed_val,
    input  logic                step_en,
    input  logic                master_sel,
    input  logic [LANES*WB-1:0] data_i,
    output logic [LANES*WB-1:0] scr_o,
    output logic [LANES-1:0]    sign_o
);

    localparam int STRIDE = WB + 1;
    localparam int HIST_W = LANES * STRIDE;

    poly_e              poly;
    logic [W-1:0]       lfsr_state;
    logic [HIST_W-1:0]  hist;

    assign poly = master_sel ? POLY_MASTER : POLY_SLAVE;

    scr4_lfsr #(
        .W     (W),
        .TAP_M (TAP_M),
        .TAP_S (TAP_S),
        .DEFV  (DEFV[W-1:0])
    ) i_lfsr (
        .clk   (clk),
        .rst   (rst),
        .load  (seed_load),
        .seed  (seed_val),
        .step  (step_en),
        .poly  (poly),
        .state (lfsr_state)
    );

    scr4_hist_ext #(
        .W      (W),
        .TAP_M  (TAP_M),
        .TAP_S  (TAP_S),
        .HIST_W (HIST_W)
    ) i_hist (
        .state (lfsr_state),
        .poly  (poly),
        .hist  (hist)
    );

    for (genvar p = 0; p < LANES; p++) begin : g_lane
        scr4_lane #(.WB(WB)) i_lane (
            .clk  (clk),
            .rst  (rst),
            .load (seed_load),
            .step (step_en),
            .data (data_i[p*WB +: WB]),
            .mask (hist[p*STRIDE +: STRIDE]),
            .word (scr_o[p*WB +: WB]),
            .sign (sign_o[p])
        );
    end

endmodule

// File: rtl/scr4_gen_chk.sv
module scr4_gen_chk
    import scr4_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          seed_load,
    input logic [STATE_BITS-1:0]         seed_val,
    input logic                          step_en,
    input logic                          master_sel,
    input logic [LANES_DEF*WORD_BITS-1:0] scr_o,
    input logic [LANES_DEF-1:0]          sign_o,
    input logic [STATE_BITS-1:0]         lfsr_state
);

    localparam int W = STATE_BITS;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (lfsr_state == SEED_DEF && scr_o == '0 && sign_o == '0));

    // R2
    master_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && !seed_load && master_sel) |=>
        lfsr_state == {$past(lfsr_state[W-2:0]),
                       $past(lfsr_state[W-1] ^ lfsr_state[TAP_M_DEF-1])});

    // R3
    slave_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && !seed_load && !master_sel) |=>
        lfsr_state == {$past(lfsr_state[W-2:0]),
                       $past(lfsr_state[W-1] ^ lfsr_state[TAP_S_DEF-1])});

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !seed_load) |=>
        ($stable(lfsr_state) && $stable(scr_o) && $stable(sign_o)));

    // R5
    seed_load_chk: assert property (@(posedge clk) disable iff (rst)
        (seed_load && seed_val != '0) |=>
        (lfsr_state == $past(seed_val) && $stable(scr_o) && $stable(sign_o)));

    // R6
    zero_seed_chk: assert property (@(posedge clk) disable iff (rst)
        (seed_load && seed_val == '0) |=> lfsr_state == SEED_DEF);

    // R6
    never_zero_chk: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> lfsr_state != '0);

    // R8
    lane0_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && !seed_load) |=> sign_o[0] == $past(lfsr_state[WORD_BITS]));

endmodule

bind scr4_gen scr4_gen_chk i_chk (.*);

// File: tb/test_scr4_gen.sv
module test_scr4_gen;

    localparam int W     = 33;
    localparam int LANES = 4;
    localparam int WB    = 10;
    localparam int DW    = LANES * WB;
    localparam logic [W-1:0] DEF_SEED = 33'h1_2345_6789;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          seed_load = 1'b0;
    logic [W-1:0]  seed_val = '0;
    logic          step_en = 1'b0;
    logic          master_sel = 1'b1;
    logic [DW-1:0] data_i = '0;
    logic [DW-1:0] scr_o;
    logic [LANES-1:0] sign_o;

    always #10 clk = ~clk;

    scr4_gen i_scr4_gen (
        .clk        (clk),
        .rst        (rst),
        .seed_load  (seed_load),
        .seed_val   (seed_val),
        .step_en    (step_en),
        .master_sel (master_sel),
        .data_i     (data_i),
        .scr_o      (scr_o),
        .sign_o     (sign_o)
    );

    typedef struct {
        logic [DW-1:0]    scr;
        logic [LANES-1:0] sgn;
        logic [DW-1:0]    dat;
        logic [DW-1:0]    msk;
        string            tag;
    } exp_t;

    exp_t q[$];

    int errors = 0;
    int checks = 0;

    logic [W-1:0] ref_s = DEF_SEED;

    logic          log_on = 1'b0;
    int            log_n = 0;
    logic [WB:0]   rec [0:LANES-1][0:63];

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_hist(input logic [W-1:0] s, input int k);
        logic [63:0] e;
        for (int i = 0; i < 64; i++) begin
            if (i < W) e[i] = s[i];
            else       e[i] = e[i-W] ^ e[i-W+k];
        end
        return e;
    endfunction

    // Driver: one symbol step with given data and polynomial
    task automatic do_step(input logic [DW-1:0] d, input logic ms);
        exp_t        x;
        logic [63:0] h;
        int          k;
        @(negedge clk);
        data_i     = d;
        master_sel = ms;
        step_en    = 1'b1;
        seed_load  = 1'b0;
        k = ms ? 13 : 20;
        h = ref_hist(ref_s, k);
        for (int p = 0; p < LANES; p++) begin
            for (int j = 0; j < WB; j++)
                x.msk[p*WB+j] = h[11*p+j];
            x.sgn[p] = h[11*p+10];
        end
        x.scr = d ^ x.msk;
        x.dat = d;
        x.tag = ms ? "R7 R8 (R2 master)" : "R7 R8 (R3 slave)";
        q.push_back(x);
        ref_s = {ref_s[W-2:0], ref_s[W-1] ^ ref_s[k-1]};
    endtask

    task automatic do_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_en   = 1'b0;
            seed_load = 1'b0;
            data_i    = {DW{1'b1}};
        end
    endtask

    task automatic do_load(input logic [W-1:0] v, input logic with_step);
        @(negedge clk);
        seed_load = 1'b1;
        seed_val  = v;
        step_en   = with_step;
        data_i    = 40'h55_AA55_AA55;
        ref_s = (v == '0) ? DEF_SEED : v;
    endtask

    // Monitor: pops expected items for every step edge, checks hold otherwise
    logic             cap;
    logic             cap_rst;
    logic [DW-1:0]    last_scr = '0;
    logic [LANES-1:0] last_sgn = '0;

    always @(posedge clk) begin
        cap     = step_en && !seed_load && !rst;
        cap_rst = rst;
        #2;
        if (cap_rst) begin
            last_scr = '0;
            last_sgn = '0;
        end else if (cap) begin
            if (q.size() == 0) begin
                check(1'b0, "R7 unexpected step", 64'(scr_o), 64'd0);
            end else begin
                exp_t x;
                x = q.pop_front();
                check(scr_o == x.scr, x.tag, 64'(scr_o), 64'(x.scr));
                check(sign_o == x.sgn, x.tag, 64'(sign_o), 64'(x.sgn));
                // descrambling with the reference mask restores the data
                check((scr_o ^ x.msk) == x.dat, "R7 descramble",
                      64'(scr_o ^ x.msk), 64'(x.dat));
                if (log_on && log_n < 64) begin
                    logic [DW-1:0] m;
                    m = scr_o ^ x.dat;
                    for (int p = 0; p < LANES; p++)
                        rec[p][log_n] = {sign_o[p], m[p*WB +: WB]};
                    log_n++;
                end
            end
            last_scr = scr_o;
            last_sgn = sign_o;
        end else begin
            check(scr_o == last_scr && sign_o == last_sgn, "R4 R5 outputs hold",
                  {20'd0, sign_o, scr_o}, {20'd0, last_sgn, last_scr});
        end
    end

    bit done = 1'b0;

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs zero in reset
        check(scr_o == '0 && sign_o == '0, "R1 reset outputs",
              {20'd0, sign_o, scr_o}, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1 + R2: first steps from the default state, master, varied data
        do_step('0, 1'b1);
        do_step({DW{1'b1}}, 1'b1);
        for (int i = 0; i < 20; i++)
            do_step(40'(64'h9E37_79B9_7F4A_7C15 * (i + 1)), 1'b1);

        // R4: idle keeps state and outputs
        do_idle(4);
        do_step(40'h12_3456_789A, 1'b1);

        // R3: slave polynomial
        for (int i = 0; i < 25; i++)
            do_step(40'(i * 40'h0F_0F0F_0F0F + i), 1'b0);

        // R5: load with step_en high at the same edge, outputs hold
        do_load(33'h0_DEAD_BEEF, 1'b1);
        do_step(40'hFF_0000_FFFF, 1'b0);
        do_step(40'h00_FFFF_0000, 1'b1);

        // R6: zero seed gives default state
        do_load('0, 1'b0);
        do_idle(1);
        for (int i = 0; i < 5; i++)
            do_step(40'(i * 7), 1'b1);

        // R9: fixed inter-pair delay, master then slave
        for (int r = 0; r < 2; r++) begin
            do_load(r == 0 ? 33'h1_F00D_CAFE : 33'h0_0000_0003, 1'b0);
            do_idle(2);
            log_n  = 0;
            log_on = 1'b1;
            for (int i = 0; i < 45; i++)
                do_step(40'(i * 40'h13_5791_3579), r == 0);
            do_idle(3);
            log_on = 1'b0;
            for (int p = 1; p < LANES; p++)
                for (int n = 33; n < 45; n++)
                    check(rec[p][n] == rec[0][n - 11*p], "R9 pair delay",
                          64'(rec[p][n]), 64'(rec[0][n - 11*p]));
        end

        do_idle(3);
        check(q.size() == 0, "R7 pending items", 64'(q.size()), 64'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule